// File: doc/BRIEF.md
# Line-Aliasing Request Admission Table

This block sits between a processor's load/store path and its first-level cache controller and decides, in the cycle a request arrives, whether that request may go downstream. Requests are tracked per cache line in two small fully associative tables. Reads go in one table and writes in the other. A new request is answered with one of four status codes: issued, merged, aliased or full. An issued request raises an issue strobe in the same cycle. The strobe carries the type of access the cache controller should perform and the hit latency to charge for it.

Pending reads and writes to the same line exclude each other. Two writes to one line also exclude each other, and so do two reads, with one exception: a speculative load that meets a pending speculative load to the same line is folded into it instead of being refused. A locked read-modify-write read locks its line when it completes. Until the matching locked write completes, every other access to that line is refused. Completions return a line address and free the matching entry. Four counters record each refusal by its conflict kind.

Top module: `line_admit_table`

## Requirements
- R1: A request gets status 3 (full) when the outstanding count is at least MAX_OUT, or when the table it targets has no free entry. This check comes before every other check, and a full request changes neither counter nor table.
- R2: When a request of kind 6 (locked RMW read) completes through the write completion port, its line becomes locked. While the line is locked, any request to it other than kind 7 (locked RMW write) gets status 2 (aliased), and no alias counter changes. Completion of a kind-7 entry unlocks the line. Requests to other lines are unaffected.
- R3: Kinds 3 (store), 4 (RMW read), 5 (RMW write), 6, 7, 8 (load-linked), 9 (store-conditional), 10 (flush) and kind 0 with the store-check input set are write-class. Such a request gets status 2 if its line is pending in the read table, and the store-on-load counter increments. Otherwise it gets status 2 if its line is pending in the write table, and the store-on-store counter increments.
- R4: Kinds 0 (load), 1 (speculative load) and 2 (instruction fetch) are read-class. Such a request gets status 2 if its line is pending in the write table, and the load-on-store counter increments. Otherwise it gets status 2 if its line is pending in the read table, and the load-on-load counter increments, except as stated in R5.
- R5: A kind-1 request whose line is pending in the read table as a kind-1 entry gets status 1 (merged). It raises no issue strobe, and the outstanding count stays the same.
- R6: The issue type is encoded as: 0 load, 1 instruction fetch, 2 store, 3 atomic, 4 flush, 5 speculative load. Kinds 8 and 9 issue as 3. Kinds 3 to 7 and a store-check load issue as 2. Kind 10 issues as 4, and kinds 0, 1 and 2 issue as 0, 5 and 1.
- R7: An issued instruction fetch carries latency ICACHE_LAT. Every other issued request carries DCACHE_LAT.
- R8: A completion whose line is pending in its table frees that entry and lowers the outstanding count by one at the next edge. A completion for a line that is not pending has no effect.
- R9: An admitted request gets status 0, and the issue strobe is high in the same cycle. The outstanding count rises by one at the next clock edge.
- R10: After reset the outstanding count and all four alias counters are zero, no line is locked, and both tables are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_kind | input | 4 | Request kind code (see R3, R4) |
| req_store_chk | input | 1 | Store-check flag for a plain load |
| req_addr | input | ADDR_W | Byte address of the request |
| rsp_status | output | 2 | 0 issued, 1 merged, 2 aliased, 3 full |
| iss_valid | output | 1 | Request goes downstream this cycle |
| iss_type | output | 3 | Downstream access type (R6) |
| iss_latency | output | LAT_W | Hit latency to charge |
| rd_done_valid | input | 1 | Read-table completion |
| rd_done_line | input | ADDR_W-OFS_W | Line address of the read completion |
| wr_done_valid | input | 1 | Write-table completion |
| wr_done_line | input | ADDR_W-OFS_W | Line address of the write completion |
| outstanding | output | $clog2(MAX_OUT+1) | Number of pending entries |
| cnt_store_on_load | output | CNT_W | Write refused by a pending read |
| cnt_store_on_store | output | CNT_W | Write refused by a pending write |
| cnt_load_on_load | output | CNT_W | Read refused by a pending read |
| cnt_load_on_store | output | CNT_W | Read refused by a pending write |

## Verification
Directed sequences place each request class against each kind of pending entry. Writes are tried behind reads and behind writes, and reads behind writes and behind reads. These cases separate the four conflict counters and show which of two simultaneous conflicts is charged. Speculative loads are sent against a pending speculative load and against a pending fetch, which distinguishes a merge from a refusal. The lock sequence sends loads to the locked line and to a different line while the lock is held, and then a locked write. These show that the lock is checked per line and that only the locked write gets past it. The full cases fill the outstanding limit with an aliasing request waiting, and separately fill the read table while the write table still has room. Together they show that the full check comes first and which table's space is checked.

// File: rtl/lat_pkg.sv
package lat_pkg;

  typedef enum logic [3:0] {
    RQ_LOAD    = 4'd0,
    RQ_SPEC    = 4'd1,
    RQ_IFETCH  = 4'd2,
    RQ_STORE   = 4'd3,
    RQ_RMW_RD  = 4'd4,
    RQ_RMW_WR  = 4'd5,
    RQ_LOCK_RD = 4'd6,
    RQ_LOCK_WR = 4'd7,
    RQ_LL      = 4'd8,
    RQ_SC      = 4'd9,
    RQ_FLUSH   = 4'd10
  } req_kind_e;

  typedef enum logic [1:0] {
    STS_ISSUED  = 2'd0,
    STS_MERGED  = 2'd1,
    STS_ALIASED = 2'd2,
    STS_FULL    = 2'd3
  } status_e;

  typedef enum logic [2:0] {
    DS_LOAD   = 3'd0,
    DS_IFETCH = 3'd1,
    DS_STORE  = 3'd2,
    DS_ATOMIC = 3'd3,
    DS_FLUSH  = 3'd4,
    DS_SPEC   = 3'd5
  } ds_type_e;

endpackage

// File: rtl/req_classify.sv
module req_classify
  import lat_pkg::*;
#(
  parameter int LAT_W      = 4,
  parameter int ICACHE_LAT = 1,
  parameter int DCACHE_LAT = 2
) (
  input  logic [3:0]       kind,
  input  logic             store_chk,
  output logic [3:0]       prim_kind,
  output logic             is_write,
  output logic             is_spec,
  output logic             is_lock_wr,
  output logic [2:0]       ds_type,
  output logic [LAT_W-1:0] latency
);

  always_comb begin
    prim_kind  = kind;
    is_write   = 1'b0;
    ds_type    = DS_LOAD;
    case (kind)
      RQ_LOAD: begin
        if (store_chk) begin
          prim_kind = RQ_RMW_RD;
          is_write  = 1'b1;
          ds_type   = DS_STORE;
        end
      end
      RQ_SPEC:   ds_type = DS_SPEC;
      RQ_IFETCH: ds_type = DS_IFETCH;
      RQ_STORE, RQ_RMW_RD, RQ_RMW_WR, RQ_LOCK_RD, RQ_LOCK_WR: begin
        is_write = 1'b1;
        ds_type  = DS_STORE;
      end
      RQ_LL, RQ_SC: begin
        is_write = 1'b1;
        ds_type  = DS_ATOMIC;
      end
      RQ_FLUSH: begin
        is_write = 1'b1;
        ds_type  = DS_FLUSH;
      end
      default: prim_kind = RQ_LOAD;
    endcase
    is_spec    = (kind == RQ_SPEC);
    is_lock_wr = (kind == RQ_LOCK_WR);
    latency    = (kind == RQ_IFETCH) ? LAT_W'(ICACHE_LAT) : LAT_W'(DCACHE_LAT);
  end

endmodule

// File: rtl/line_cam.sv
module line_cam #(
  parameter int DEPTH  = 4,
  parameter int LINE_W = 26,
  parameter int META_W = 4,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] look_line,
  output logic              look_hit,
  output logic [META_W-1:0] look_meta,
  input  logic              ins_en,
  input  logic [LINE_W-1:0] ins_line,
  input  logic [META_W-1:0] ins_meta,
  output logic              has_free,
  input  logic              rm_en,
  input  logic [LINE_W-1:0] rm_line,
  output logic              rm_hit,
  output logic [META_W-1:0] rm_meta,
  output logic [OCC_W-1:0]  occupancy
);

  logic [DEPTH-1:0]              vld_q, vld_nx;
  logic [DEPTH-1:0][LINE_W-1:0]  line_q;
  logic [DEPTH-1:0][META_W-1:0]  meta_q;
  logic [DEPTH-1:0]              look_match, rm_match;
  logic [IDX_W-1:0]              free_idx;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign look_match[g] = vld_q[g] && (line_q[g] == look_line);
    assign rm_match[g]   = vld_q[g] && (line_q[g] == rm_line);
  end

  always_comb begin
    look_hit  = 1'b0;
    look_meta = '0;
    rm_hit    = 1'b0;
    rm_meta   = '0;
    has_free  = 1'b0;
    free_idx  = '0;
    occupancy = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        has_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (look_match[i]) begin
        look_hit  = 1'b1;
        look_meta = meta_q[i];
      end
      if (rm_match[i]) begin
        rm_hit  = rm_en;
        rm_meta = meta_q[i];
      end
      occupancy = occupancy + OCC_W'(vld_q[i]);
    end
  end

  always_comb begin
    vld_nx = vld_q;
    if (rm_en) vld_nx = vld_nx & ~rm_match;
    if (ins_en && has_free) vld_nx[free_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_nx;
  end

  always_ff @(posedge clk) begin
    if (ins_en && has_free) begin
      line_q[free_idx] <= ins_line;
      meta_q[free_idx] <= ins_meta;
    end
  end

endmodule

// File: rtl/alias_counters.sv
module alias_counters #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       bump,
  output logic [CNT_W-1:0] cnt_sol,
  output logic [CNT_W-1:0] cnt_sos,
  output logic [CNT_W-1:0] cnt_lol,
  output logic [CNT_W-1:0] cnt_los
);

  logic [3:0][CNT_W-1:0] cnt_q, cnt_nx;

  for (genvar g = 0; g < 4; g++) begin : g_cnt
    assign cnt_nx[g] = cnt_q[g] + CNT_W'(1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q[g] <= '0;
      else if (bump[g]) cnt_q[g] <= cnt_nx[g];
    end
  end

  assign cnt_sol = cnt_q[0];
  assign cnt_sos = cnt_q[1];
  assign cnt_lol = cnt_q[2];
  assign cnt_los = cnt_q[3];

endmodule

// File: rtl/line_admit_table.sv
module line_admit_table
  import lat_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int OFS_W      = 6,
  parameter int DEPTH      = 4,
  parameter int MAX_OUT    = 6,
  parameter int LAT_W      = 4,
  parameter int ICACHE_LAT = 1,
  parameter int DCACHE_LAT = 2,
  parameter int CNT_W      = 8,
  localparam int LINE_W    = ADDR_W - OFS_W,
  localparam int OUT_W     = $clog2(MAX_OUT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [3:0]        req_kind,
  input  logic              req_store_chk,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [1:0]        rsp_status,
  output logic              iss_valid,
  output logic [2:0]        iss_type,
  output logic [LAT_W-1:0]  iss_latency,
  input  logic              rd_done_valid,
  input  logic [LINE_W-1:0] rd_done_line,
  input  logic              wr_done_valid,
  input  logic [LINE_W-1:0] wr_done_line,
  output logic [OUT_W-1:0]  outstanding,
  output logic [CNT_W-1:0]  cnt_store_on_load,
  output logic [CNT_W-1:0]  cnt_store_on_store,
  output logic [CNT_W-1:0]  cnt_load_on_load,
  output logic [CNT_W-1:0]  cnt_load_on_store
);

  localparam int OCC_W = $clog2(DEPTH + 1);

  logic [LINE_W-1:0] req_line;
  logic [3:0]        prim_kind;
  logic              is_write, is_spec, is_lock_wr;
  logic [2:0]        ds_type;
  logic [LAT_W-1:0]  ds_lat;

  logic              rd_hit, wr_hit, rd_free, wr_free;
  logic [3:0]        rd_hit_meta, wr_hit_meta;
  logic              rd_rm_hit, wr_rm_hit;
  logic [3:0]        rd_rm_meta, wr_rm_meta;
  logic [OCC_W-1:0]  rd_occ, wr_occ;

  logic              lock_vld_q, lock_vld_nx, lock_set;
  logic [LINE_W-1:0] lock_line_q;
  logic              line_locked, is_full;
  logic              accept;
  status_e           status;
  logic [3:0]        bump;
  logic [OUT_W-1:0]  out_q, out_nx;

  assign req_line = req_addr[ADDR_W-1:OFS_W];

  req_classify #(
    .LAT_W(LAT_W), .ICACHE_LAT(ICACHE_LAT), .DCACHE_LAT(DCACHE_LAT)
  ) u_class (
    .kind(req_kind), .store_chk(req_store_chk), .prim_kind(prim_kind),
    .is_write(is_write), .is_spec(is_spec), .is_lock_wr(is_lock_wr),
    .ds_type(ds_type), .latency(ds_lat)
  );

  line_cam #(.DEPTH(DEPTH), .LINE_W(LINE_W), .META_W(4)) u_rd_tab (
    .clk(clk), .rst_n(rst_n),
    .look_line(req_line), .look_hit(rd_hit), .look_meta(rd_hit_meta),
    .ins_en(accept && !is_write), .ins_line(req_line), .ins_meta(prim_kind),
    .has_free(rd_free),
    .rm_en(rd_done_valid), .rm_line(rd_done_line),
    .rm_hit(rd_rm_hit), .rm_meta(rd_rm_meta), .occupancy(rd_occ)
  );

  line_cam #(.DEPTH(DEPTH), .LINE_W(LINE_W), .META_W(4)) u_wr_tab (
    .clk(clk), .rst_n(rst_n),
    .look_line(req_line), .look_hit(wr_hit), .look_meta(wr_hit_meta),
    .ins_en(accept && is_write), .ins_line(req_line), .ins_meta(prim_kind),
    .has_free(wr_free),
    .rm_en(wr_done_valid), .rm_line(wr_done_line),
    .rm_hit(wr_rm_hit), .rm_meta(wr_rm_meta), .occupancy(wr_occ)
  );

  assign line_locked = lock_vld_q && (lock_line_q == req_line);
  assign is_full     = (out_q >= OUT_W'(MAX_OUT)) || (is_write ? !wr_free : !rd_free);

  // Admission decision: full, then lock, then table conflicts.
  always_comb begin
    status = STS_ISSUED;
    accept = 1'b0;
    bump   = 4'b0000;
    if (req_valid) begin
      if (is_full) begin
        status = STS_FULL;
      end else if (line_locked && !is_lock_wr) begin
        status = STS_ALIASED;
      end else if (is_write) begin
        if (rd_hit) begin
          status  = STS_ALIASED;
          bump[0] = 1'b1;
        end else if (wr_hit) begin
          status  = STS_ALIASED;
          bump[1] = 1'b1;
        end else begin
          accept = 1'b1;
        end
      end else begin
        if (wr_hit) begin
          status  = STS_ALIASED;
          bump[3] = 1'b1;
        end else if (rd_hit) begin
          if (is_spec && (rd_hit_meta == RQ_SPEC)) begin
            status = STS_MERGED;
          end else begin
            status  = STS_ALIASED;
            bump[2] = 1'b1;
          end
        end else begin
          accept = 1'b1;
        end
      end
    end
  end

  assign rsp_status  = status;
  assign iss_valid   = accept;
  assign iss_type    = ds_type;
  assign iss_latency = ds_lat;

  // Line lock next state
  always_comb begin
    lock_vld_nx = lock_vld_q;
    lock_set    = 1'b0;
    if (wr_rm_hit) begin
      if (wr_rm_meta == RQ_LOCK_RD) begin
        lock_vld_nx = 1'b1;
        lock_set    = 1'b1;
      end else if (wr_rm_meta == RQ_LOCK_WR) begin
        lock_vld_nx = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_vld_q <= 1'b0;
    else        lock_vld_q <= lock_vld_nx;
  end

  always_ff @(posedge clk) begin
    if (lock_set) lock_line_q <= wr_done_line;
  end

  // Outstanding count
  always_comb begin
    out_nx = out_q + OUT_W'(accept) - OUT_W'(rd_rm_hit) - OUT_W'(wr_rm_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_nx;
  end

  assign outstanding = out_q;

  alias_counters #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .bump(bump),
    .cnt_sol(cnt_store_on_load), .cnt_sos(cnt_store_on_store),
    .cnt_lol(cnt_load_on_load), .cnt_los(cnt_load_on_store)
  );

endmodule

// File: rtl/line_admit_checker.sv
module line_admit_checker #(
  parameter int MAX_OUT    = 6,
  parameter int OUT_W      = 3,
  parameter int OCC_W      = 3,
  parameter int LAT_W      = 4,
  parameter int ICACHE_LAT = 1,
  parameter int DCACHE_LAT = 2,
  parameter int CNT_W      = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [1:0]       rsp_status,
  input logic             iss_valid,
  input logic [2:0]       iss_type,
  input logic [LAT_W-1:0] iss_latency,
  input logic             rd_done_valid,
  input logic             wr_done_valid,
  input logic [OUT_W-1:0] outstanding,
  input logic [OCC_W-1:0] rd_occ,
  input logic [OCC_W-1:0] wr_occ,
  input logic [CNT_W-1:0] c0,
  input logic [CNT_W-1:0] c1,
  input logic [CNT_W-1:0] c2,
  input logic [CNT_W-1:0] c3
);

  assert_full_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && outstanding >= OUT_W'(MAX_OUT)) |-> rsp_status == 2'd3);

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding <= OUT_W'(MAX_OUT));

  assert_issue_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (req_valid && rsp_status == 2'd0));

  assert_issue_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !rd_done_valid && !wr_done_valid)
      |=> outstanding == $past(outstanding) + OUT_W'(1));

  assert_merge_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rsp_status == 2'd1) |-> !iss_valid);

  assert_fetch_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_type == 3'd1) |-> iss_latency == LAT_W'(ICACHE_LAT));

  assert_data_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_type != 3'd1) |-> iss_latency == LAT_W'(DCACHE_LAT));

  // R3 and R4: counters move only on an aliased answer
  assert_counters_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && rsp_status == 2'd2)
      |=> ($stable(c0) && $stable(c1) && $stable(c2) && $stable(c3)));

  assert_occupancy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    32'(outstanding) == 32'(rd_occ) + 32'(wr_occ));

endmodule

bind line_admit_table line_admit_checker #(
  .MAX_OUT(MAX_OUT), .OUT_W(OUT_W), .OCC_W(OCC_W), .LAT_W(LAT_W),
  .ICACHE_LAT(ICACHE_LAT), .DCACHE_LAT(DCACHE_LAT), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_status(rsp_status),
  .iss_valid(iss_valid), .iss_type(iss_type), .iss_latency(iss_latency),
  .rd_done_valid(rd_done_valid), .wr_done_valid(wr_done_valid),
  .outstanding(outstanding), .rd_occ(rd_occ), .wr_occ(wr_occ),
  .c0(cnt_store_on_load), .c1(cnt_store_on_store),
  .c2(cnt_load_on_load), .c3(cnt_load_on_store)
);

// File: tb/line_admit_table_tb_top.sv
module line_admit_table_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int OFS_W  = 6;
  localparam int LINE_W = ADDR_W - OFS_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [3:0]        req_kind = '0;
  logic              req_store_chk = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0]        rsp_status;
  logic              iss_valid;
  logic [2:0]        iss_type;
  logic [3:0]        iss_latency;
  logic              rd_done_valid = 1'b0;
  logic [LINE_W-1:0] rd_done_line = '0;
  logic              wr_done_valid = 1'b0;
  logic [LINE_W-1:0] wr_done_line = '0;
  logic [2:0]        outstanding;
  logic [7:0]        c_sol, c_sos, c_lol, c_los;

  int n_run = 0, n_fail = 0;
  int e_out = 0, e_sol = 0, e_sos = 0, e_lol = 0, e_los = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_admit_table dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_store_chk(req_store_chk), .req_addr(req_addr),
    .rsp_status(rsp_status), .iss_valid(iss_valid), .iss_type(iss_type),
    .iss_latency(iss_latency), .rd_done_valid(rd_done_valid),
    .rd_done_line(rd_done_line), .wr_done_valid(wr_done_valid),
    .wr_done_line(wr_done_line), .outstanding(outstanding),
    .cnt_store_on_load(c_sol), .cnt_store_on_store(c_sos),
    .cnt_load_on_load(c_lol), .cnt_load_on_store(c_los)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_counters(input string tag);
    check({tag, " store_on_load"}, int'(c_sol), e_sol);
    check({tag, " store_on_store"}, int'(c_sos), e_sos);
    check({tag, " load_on_load"}, int'(c_lol), e_lol);
    check({tag, " load_on_store"}, int'(c_los), e_los);
  endtask

  // exp_ds / exp_lat are only checked when exp_st is 0 (issued)
  task automatic send(input int kind, input bit chk, input int addr,
                      input int exp_st, input int exp_ds, input int exp_lat,
                      input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_kind = 4'(kind); req_store_chk = chk;
    req_addr = ADDR_W'(addr);
    #1;
    check({tag, " status"}, int'(rsp_status), exp_st);
    check({tag, " strobe"}, int'(iss_valid), (exp_st == 0) ? 1 : 0);
    if (exp_st == 0) begin
      check({tag, " type"}, int'(iss_type), exp_ds);
      check({tag, " latency"}, int'(iss_latency), exp_lat);
      e_out++;
    end
    @(posedge clk); #1;
    req_valid = 1'b0; req_store_chk = 1'b0;
    check({tag, " R9 outstanding"}, int'(outstanding), e_out);
  endtask

  task automatic done(input bit wr, input int line, input bit present,
                      input string tag);
    @(negedge clk);
    if (wr) begin wr_done_valid = 1'b1; wr_done_line = LINE_W'(line); end
    else    begin rd_done_valid = 1'b1; rd_done_line = LINE_W'(line); end
    @(posedge clk); #1;
    wr_done_valid = 1'b0; rd_done_valid = 1'b0;
    if (present) e_out--;
    check({tag, " outstanding"}, int'(outstanding), e_out);
  endtask

  task automatic t_reset();
    #1;
    check("R10 outstanding", int'(outstanding), 0);
    check("R10 strobe", int'(iss_valid), 0);
    check_counters("R10");
  endtask

  task automatic t_basic_alias();
    send(0, 0, 'h1000, 0, 0, 2, "R9 load");
    send(2, 0, 'h2000, 0, 1, 1, "R7 ifetch");
    send(0, 0, 'h1010, 2, 0, 0, "R4 load on load"); e_lol++;
    send(3, 0, 'h1004, 2, 0, 0, "R3 store on load"); e_sol++;
    check_counters("R3 R4 read pending");
    done(0, 'h40, 1, "R8 read completion");
    send(3, 0, 'h1000, 0, 2, 2, "R6 store");
    send(3, 0, 'h1020, 2, 0, 0, "R3 store on store"); e_sos++;
    send(0, 0, 'h1030, 2, 0, 0, "R4 load on store"); e_los++;
    check_counters("R3 R4 write pending");
  endtask

  task automatic t_spec();
    send(1, 0, 'h3000, 0, 5, 2, "R6 spec load");
    send(1, 0, 'h3008, 1, 0, 0, "R5 spec merge");
    send(0, 0, 'h3000, 2, 0, 0, "R4 load on spec"); e_lol++;
    send(1, 0, 'h2004, 2, 0, 0, "R5 spec on ifetch"); e_lol++;
    check_counters("R5");
  endtask

  task automatic t_mapping_full();
    send(8, 0, 'h4000, 0, 3, 2, "R6 load-linked");
    send(9, 0, 'h5000, 0, 3, 2, "R6 store-conditional");
    send(0, 1, 'h6000, 0, 2, 2, "R6 store-check load");
    send(0, 0, 'h7000, 3, 0, 0, "R1 full load");
    send(3, 0, 'h1000, 3, 0, 0, "R1 full before alias");
    check_counters("R1 no count");
    done(1, 'h40, 1, "R8 wr done");
    done(1, 'h100, 1, "R8 wr done LL");
    done(1, 'h140, 1, "R8 wr done SC");
    done(1, 'h180, 1, "R8 wr done chk");
    done(0, 'h80, 1, "R8 rd done fetch");
    done(0, 'hC0, 1, "R8 rd done spec");
    done(0, 'h999, 0, "R8 absent line ignored");
    send(3, 0, 'h1000, 0, 2, 2, "R8 line reusable");
    done(1, 'h40, 1, "R8 wr done again");
  endtask

  task automatic t_lock();
    send(6, 0, 'h8000, 0, 2, 2, "R6 locked read");
    done(1, 'h200, 1, "R2 locked read completes");
    send(0, 0, 'h8010, 2, 0, 0, "R2 load blocked");
    send(3, 0, 'h8000, 2, 0, 0, "R2 store blocked");
    check_counters("R2 no count");
    send(0, 0, 'h9000, 0, 0, 2, "R2 other line free");
    send(7, 0, 'h8000, 0, 2, 2, "R2 locked write passes");
    done(1, 'h200, 1, "R2 locked write completes");
    send(0, 0, 'h8000, 0, 0, 2, "R2 unlocked load");
  endtask

  task automatic t_table_full();
    send(0, 0, 'hA000, 0, 0, 2, "R1 fill read 3");
    send(0, 0, 'hB000, 0, 0, 2, "R1 fill read 4");
    send(0, 0, 'hC000, 3, 0, 0, "R1 read table full");
    send(3, 0, 'hC000, 0, 2, 2, "R1 write table has room");
    send(10, 0, 'hD000, 0, 4, 2, "R6 flush");
    check_counters("R1 final");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_basic_alias();
    t_spec();
    t_mapping_full();
    t_lock();
    t_table_full();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule